// File: doc/BRIEF.md
# Power Mode Clock Controller

This block sets the operating mode of a small microcontroller and drives the clock enables that follow from it. There are four modes: full-speed Active, a reduced-rate Power Save mode, Idle and Halt. For each mode the block decides whether the high-frequency oscillator runs and which source feeds the System Clock: the Main Clock, the divided PLL clock, Slow Clock or nothing. It also decides whether Slow Clock and the timer/watchdog clock toggle and whether the auxiliary clocks may stay on.

Software writes a single configuration word. The word holds the requested mode, an oscillator-off request, the Slow Clock source (low-frequency crystal or divided Main Clock), the Active-mode System Clock choice, the auxiliary clock requests and a wake settle count. The block refuses any setting that would leave Slow Clock without a running source, and it records that refusal in a sticky flag. A one-cycle wake pulse brings the block from Idle or Halt back to Active through an oscillator settle period. Every System Clock source change goes through a break-before-make gate sequence.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After reset the mode output is Active, with encoding 0=Active, 1=Power Save, 2=Idle, 3=Halt. In this state the high-frequency oscillator enable is 1, the System Clock gate vector is 3'b001, Slow Clock and the timer clock run, the auxiliary enables are 0, the error flag is 0 and the waking flag is 0.
- R2: In Active the high-frequency oscillator enable is always 1, and an oscillator-off request written with Active is ignored without an error. The System Clock gate vector is 3'b001 (Main Clock) when the PLL select bit is 0 and 3'b010 (PLL) when it is 1.
- R3: In Power Save the System Clock gate vector is 3'b100 (Slow Clock).
- R4: In Idle and in Halt the System Clock gate vector is 3'b000.
- R5: A write of Power Save or Idle with the oscillator-off bit set and the Slow Clock divider select at 0 (crystal) turns the high-frequency oscillator enable off. A write with the off bit clear leaves it on.
- R6: A write of Power Save or Idle with the oscillator-off bit set and the divider select at 1 leaves the oscillator on and sets the error flag. The flag stays 1 until reset.
- R7: In Halt the oscillator enable, the Slow Clock run and the timer clock run outputs are 0 (except during a wake settle). The low-frequency oscillator enable is 1 in every mode.
- R8: Each auxiliary clock enable equals its request bit ANDed with the high-frequency oscillator enable.
- R9: A wake pulse sampled in Idle or Halt raises the waking flag and the oscillator enable on the next edge, and clears the PLL select. The mode becomes Active SETTLE+1 edges after the pulse is sampled, so the gate vector returns to 3'b001. A wake pulse in Active or Power Save has no effect.
- R10: Configuration writes sampled while waking, or in the same cycle as an accepted wake pulse, are ignored.
- R11: At most one gate bit is high at any time. When the System Clock moves between two different sources, all gates stay low for exactly GAP_CYCLES cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | always-running controller clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| cfg_we_i | input | 1 | configuration write strobe |
| cfg_mode_i | input | 2 | requested mode |
| cfg_hf_off_i | input | 1 | request high-frequency oscillator off |
| cfg_slow_div_i | input | 1 | Slow Clock from divided Main Clock (1) or crystal (0) |
| cfg_sys_pll_i | input | 1 | Active System Clock from PLL (1) or Main Clock (0) |
| cfg_aux_i | input | N_AUX | auxiliary clock requests |
| cfg_settle_i | input | CNT_W | wake settle count |
| wake_i | input | 1 | single-cycle wake event |
| mode_o | output | 2 | current mode |
| waking_o | output | 1 | wake settle in progress |
| hf_osc_en_o | output | 1 | high-frequency oscillator enable |
| lf_osc_en_o | output | 1 | low-frequency oscillator enable |
| sys_gate_o | output | 3 | System Clock gates: bit0 Main, bit1 PLL, bit2 Slow |
| slow_div_sel_o | output | 1 | Slow Clock source select |
| slow_run_o | output | 1 | Slow Clock toggling enable |
| tmr_clk_run_o | output | 1 | timer/watchdog clock enable |
| aux_en_o | output | N_AUX | auxiliary clock enables |
| cfg_err_o | output | 1 | sticky refused-setting flag |

## Verification
A wake pulse and a configuration write can arrive in the same cycle, and only the wake may take effect. The bench drives both on one edge while the block sits in Idle, each asking for a different target mode. It then writes Halt again during the settle period. The run is judged by the mode sequence: Idle with waking raised, then Active, and never Power Save or Halt.

// File: rtl/pmcc_pkg.sv
package pmcc_pkg;

   typedef enum logic [1:0] {
      MD_ACTIVE = 2'd0,
      MD_PSAVE  = 2'd1,
      MD_IDLE   = 2'd2,
      MD_HALT   = 2'd3
   } pm_mode_e;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_MAIN = 2'd1,
      SRC_PLL  = 2'd2,
      SRC_SLOW = 2'd3
   } sys_src_e;

   localparam int unsigned N_GATES = 3;

   function automatic logic is_reduced(pm_mode_e m);
      return (m == MD_PSAVE) || (m == MD_IDLE);
   endfunction

   function automatic logic is_dormant(pm_mode_e m);
      return (m == MD_IDLE) || (m == MD_HALT);
   endfunction

endpackage

// File: rtl/pmcc_mode_fsm.sv
module pmcc_mode_fsm
   import pmcc_pkg::*;
#(
   parameter int unsigned CNT_W = 8,
   parameter int unsigned N_AUX = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cfg_we_i,
   input  pm_mode_e          cfg_mode_i,
   input  logic              cfg_hf_off_i,
   input  logic              cfg_slow_div_i,
   input  logic              cfg_sys_pll_i,
   input  logic [N_AUX-1:0]  cfg_aux_i,
   input  logic [CNT_W-1:0]  cfg_settle_i,
   input  logic              wake_i,
   output pm_mode_e          mode_o,
   output logic              waking_o,
   output logic              hf_off_o,
   output logic              slow_div_o,
   output logic              sys_pll_o,
   output logic [N_AUX-1:0]  aux_req_o,
   output logic              err_o
);

   pm_mode_e          mode_q;
   logic              waking_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  settle_q;
   logic              hf_off_q;
   logic              slow_div_q;
   logic              sys_pll_q;
   logic [N_AUX-1:0]  aux_q;
   logic              err_q;

   logic wake_hit;
   logic wr_ok;
   logic off_allowed;
   logic off_refused;

   // wake wins over a write in the same cycle
   assign wake_hit    = wake_i && is_dormant(mode_q) && !waking_q;
   assign wr_ok       = cfg_we_i && !waking_q && !wake_hit;
   assign off_allowed = is_reduced(cfg_mode_i) && !cfg_slow_div_i;
   assign off_refused = wr_ok && is_reduced(cfg_mode_i) && cfg_hf_off_i && cfg_slow_div_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q     <= MD_ACTIVE;
         waking_q   <= 1'b0;
         cnt_q      <= '0;
         settle_q   <= '0;
         hf_off_q   <= 1'b0;
         slow_div_q <= 1'b0;
         sys_pll_q  <= 1'b0;
         aux_q      <= '0;
      end else if (wake_hit) begin
         waking_q  <= 1'b1;
         cnt_q     <= '0;
         hf_off_q  <= 1'b0;
         sys_pll_q <= 1'b0;
      end else if (waking_q) begin
         if (cnt_q == settle_q) begin
            mode_q   <= MD_ACTIVE;
            waking_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end else if (wr_ok) begin
         mode_q     <= cfg_mode_i;
         hf_off_q   <= cfg_hf_off_i && off_allowed;
         slow_div_q <= cfg_slow_div_i;
         sys_pll_q  <= cfg_sys_pll_i;
         aux_q      <= cfg_aux_i;
         settle_q   <= cfg_settle_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         err_q <= 1'b0;
      end else if (off_refused) begin
         err_q <= 1'b1;
      end
   end

   assign mode_o     = mode_q;
   assign waking_o   = waking_q;
   assign hf_off_o   = hf_off_q;
   assign slow_div_o = slow_div_q;
   assign sys_pll_o  = sys_pll_q;
   assign aux_req_o  = aux_q;
   assign err_o      = err_q;

endmodule

// File: rtl/pmcc_clk_switch.sv
module pmcc_clk_switch
   import pmcc_pkg::*;
#(
   parameter int unsigned GAP_CYCLES = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  sys_src_e           tgt_i,
   output logic [N_GATES-1:0] gate_o
);

   localparam int unsigned GAP_W = (GAP_CYCLES < 2) ? 1 : $clog2(GAP_CYCLES);
   localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYCLES - 1);

   sys_src_e         cur_q;
   logic [GAP_W-1:0] gap_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cur_q <= SRC_MAIN;
         gap_q <= '0;
      end else if ((tgt_i != cur_q) && (cur_q != SRC_NONE)) begin
         // break: drop the old gate first
         cur_q <= SRC_NONE;
         gap_q <= '0;
      end else if (cur_q == SRC_NONE) begin
         if ((tgt_i != SRC_NONE) && (gap_q == GAP_LAST)) begin
            cur_q <= tgt_i;
         end else if (gap_q != GAP_LAST) begin
            gap_q <= gap_q + 1'b1;
         end
      end
   end

   for (genvar g = 0; g < N_GATES; g++) begin : g_gate
      assign gate_o[g] = (cur_q == sys_src_e'(g + 1));
   end

endmodule

// File: rtl/pwr_clk_ctrl.sv
module pwr_clk_ctrl
   import pmcc_pkg::*;
#(
   parameter int unsigned CNT_W      = 8,
   parameter int unsigned N_AUX      = 2,
   parameter int unsigned GAP_CYCLES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cfg_we_i,
   input  logic [1:0]        cfg_mode_i,
   input  logic              cfg_hf_off_i,
   input  logic              cfg_slow_div_i,
   input  logic              cfg_sys_pll_i,
   input  logic [N_AUX-1:0]  cfg_aux_i,
   input  logic [CNT_W-1:0]  cfg_settle_i,
   input  logic              wake_i,
   output logic [1:0]        mode_o,
   output logic              waking_o,
   output logic              hf_osc_en_o,
   output logic              lf_osc_en_o,
   output logic [2:0]        sys_gate_o,
   output logic              slow_div_sel_o,
   output logic              slow_run_o,
   output logic              tmr_clk_run_o,
   output logic [N_AUX-1:0]  aux_en_o,
   output logic              cfg_err_o
);

   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end
   if (N_AUX < 1) begin : g_bad_aux
      $error("N_AUX must be at least 1");
   end
   if (GAP_CYCLES < 1) begin : g_bad_gap
      $error("GAP_CYCLES must be at least 1");
   end

   pm_mode_e         mode;
   logic             waking;
   logic             hf_off;
   logic             sys_pll;
   logic [N_AUX-1:0] aux_req;
   sys_src_e         tgt_src;
   logic             hf_en;

   pmcc_mode_fsm #(
      .CNT_W (CNT_W),
      .N_AUX (N_AUX)
   ) u_fsm (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .cfg_we_i       (cfg_we_i),
      .cfg_mode_i     (pm_mode_e'(cfg_mode_i)),
      .cfg_hf_off_i   (cfg_hf_off_i),
      .cfg_slow_div_i (cfg_slow_div_i),
      .cfg_sys_pll_i  (cfg_sys_pll_i),
      .cfg_aux_i      (cfg_aux_i),
      .cfg_settle_i   (cfg_settle_i),
      .wake_i         (wake_i),
      .mode_o         (mode),
      .waking_o       (waking),
      .hf_off_o       (hf_off),
      .slow_div_o     (slow_div_sel_o),
      .sys_pll_o      (sys_pll),
      .aux_req_o      (aux_req),
      .err_o          (cfg_err_o)
   );

   always_comb begin
      unique case (mode)
         MD_ACTIVE: tgt_src = sys_pll ? SRC_PLL : SRC_MAIN;
         MD_PSAVE:  tgt_src = SRC_SLOW;
         default:   tgt_src = SRC_NONE;
      endcase
   end

   pmcc_clk_switch #(
      .GAP_CYCLES (GAP_CYCLES)
   ) u_switch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tgt_i  (tgt_src),
      .gate_o (sys_gate_o)
   );

   assign hf_en = (mode == MD_ACTIVE) || waking || (is_reduced(mode) && !hf_off);

   for (genvar a = 0; a < N_AUX; a++) begin : g_aux
      assign aux_en_o[a] = aux_req[a] && hf_en;
   end

   assign mode_o        = mode;
   assign waking_o      = waking;
   assign hf_osc_en_o   = hf_en;
   assign lf_osc_en_o   = 1'b1;
   assign slow_run_o    = (mode != MD_HALT);
   assign tmr_clk_run_o = slow_run_o;

endmodule

// File: rtl/pwr_clk_ctrl_chk.sv
module pwr_clk_ctrl_chk #(
   parameter int unsigned N_AUX = 2
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             wake_i,
   input logic [1:0]       mode_o,
   input logic             waking_o,
   input logic             hf_osc_en_o,
   input logic             lf_osc_en_o,
   input logic [2:0]       sys_gate_o,
   input logic             slow_div_sel_o,
   input logic             slow_run_o,
   input logic             tmr_clk_run_o,
   input logic [N_AUX-1:0] aux_en_o,
   input logic             cfg_err_o
);

   p_gate_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(sys_gate_o));

   p_break_before_make_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (($past(sys_gate_o) != 3'b000) && (sys_gate_o != 3'b000)) |-> (sys_gate_o == $past(sys_gate_o)));

   p_active_hf_on_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'd0) |-> hf_osc_en_o);

   p_hf_off_needs_crystal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!hf_osc_en_o && (mode_o != 2'd3)) |-> !slow_div_sel_o);

   p_err_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_err_o |=> cfg_err_o);

   p_halt_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_o == 2'd3) |-> (!slow_run_o && !tmr_clk_run_o && (waking_o || !hf_osc_en_o)));

   p_lf_always_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lf_osc_en_o);

   p_aux_needs_main_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hf_osc_en_o |-> (aux_en_o == '0));

   p_wake_starts_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wake_i && mode_o[1] && !waking_o) |=> (waking_o && hf_osc_en_o));

   p_dormant_no_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((mode_o[1]) && $stable(mode_o) && !waking_o && $past(mode_o[1])) |=> (sys_gate_o == 3'b000) || waking_o || (mode_o != $past(mode_o)));

endmodule

bind pwr_clk_ctrl pwr_clk_ctrl_chk #(.N_AUX(N_AUX)) u_chk (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .wake_i         (wake_i),
   .mode_o         (mode_o),
   .waking_o       (waking_o),
   .hf_osc_en_o    (hf_osc_en_o),
   .lf_osc_en_o    (lf_osc_en_o),
   .sys_gate_o     (sys_gate_o),
   .slow_div_sel_o (slow_div_sel_o),
   .slow_run_o     (slow_run_o),
   .tmr_clk_run_o  (tmr_clk_run_o),
   .aux_en_o       (aux_en_o),
   .cfg_err_o      (cfg_err_o)
);

// File: tb/pwr_clk_ctrl_bench.sv
module pwr_clk_ctrl_bench;

   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned CNT_W      = 8;
   localparam int unsigned N_AUX      = 2;
   localparam int unsigned GAP_CYCLES = 2;
   localparam int unsigned N_VEC      = 8;

   // {mode, off, div, pll, aux, exp_mode, exp_hf, exp_gate, exp_run, exp_aux, exp_err}
   typedef struct packed {
      logic [1:0] md;
      logic       off;
      logic       dv;
      logic       pll;
      logic [1:0] aux;
      logic [1:0] e_md;
      logic       e_hf;
      logic [2:0] e_gate;
      logic       e_run;
      logic [1:0] e_aux;
      logic       e_err;
   } vec_t;

   localparam logic [16:0] VEC [N_VEC] = '{
      {2'd0, 1'b1, 1'b0, 1'b1, 2'b11, 2'd0, 1'b1, 3'b010, 1'b1, 2'b11, 1'b0},
      {2'd1, 1'b0, 1'b0, 1'b0, 2'b01, 2'd1, 1'b1, 3'b100, 1'b1, 2'b01, 1'b0},
      {2'd1, 1'b1, 1'b0, 1'b0, 2'b11, 2'd1, 1'b0, 3'b100, 1'b1, 2'b00, 1'b0},
      {2'd1, 1'b1, 1'b1, 1'b0, 2'b10, 2'd1, 1'b1, 3'b100, 1'b1, 2'b10, 1'b1},
      {2'd2, 1'b1, 1'b0, 1'b0, 2'b01, 2'd2, 1'b0, 3'b000, 1'b1, 2'b00, 1'b1},
      {2'd2, 1'b0, 1'b1, 1'b0, 2'b11, 2'd2, 1'b1, 3'b000, 1'b1, 2'b11, 1'b1},
      {2'd3, 1'b0, 1'b0, 1'b0, 2'b11, 2'd3, 1'b0, 3'b000, 1'b0, 2'b00, 1'b1},
      {2'd0, 1'b0, 1'b0, 1'b0, 2'b00, 2'd0, 1'b1, 3'b001, 1'b1, 2'b00, 1'b1}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_we = 1'b0;
   logic [1:0]       cfg_mode = 2'd0;
   logic             cfg_hf_off = 1'b0;
   logic             cfg_slow_div = 1'b0;
   logic             cfg_sys_pll = 1'b0;
   logic [N_AUX-1:0] cfg_aux = '0;
   logic [CNT_W-1:0] cfg_settle = '0;
   logic             wake = 1'b0;

   logic [1:0]       mode;
   logic             waking;
   logic             hf_en;
   logic             lf_en;
   logic [2:0]       gate;
   logic             slow_div;
   logic             slow_run;
   logic             tmr_run;
   logic [N_AUX-1:0] aux_en;
   logic             err;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pwr_clk_ctrl #(
      .CNT_W      (CNT_W),
      .N_AUX      (N_AUX),
      .GAP_CYCLES (GAP_CYCLES)
   ) u_pwr_clk_ctrl (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .cfg_we_i       (cfg_we),
      .cfg_mode_i     (cfg_mode),
      .cfg_hf_off_i   (cfg_hf_off),
      .cfg_slow_div_i (cfg_slow_div),
      .cfg_sys_pll_i  (cfg_sys_pll),
      .cfg_aux_i      (cfg_aux),
      .cfg_settle_i   (cfg_settle),
      .wake_i         (wake),
      .mode_o         (mode),
      .waking_o       (waking),
      .hf_osc_en_o    (hf_en),
      .lf_osc_en_o    (lf_en),
      .sys_gate_o     (gate),
      .slow_div_sel_o (slow_div),
      .slow_run_o     (slow_run),
      .tmr_clk_run_o  (tmr_run),
      .aux_en_o       (aux_en),
      .cfg_err_o      (err)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [1:0] md, input logic off, input logic dv,
                            input logic pll, input logic [N_AUX-1:0] ax,
                            input logic [CNT_W-1:0] st);
      cfg_mode     = md;
      cfg_hf_off   = off;
      cfg_slow_div = dv;
      cfg_sys_pll  = pll;
      cfg_aux      = ax;
      cfg_settle   = st;
      cfg_we       = 1'b1;
      @(negedge clk);
      cfg_we       = 1'b0;
   endtask

   task automatic pulse_wake();
      wake = 1'b1;
      @(negedge clk);
      wake = 1'b0;
   endtask

   task automatic check_reset_state(input string tag);
      check({tag, " mode"},  32'(mode), 32'd0);
      check({tag, " hf"},    32'(hf_en), 32'd1);
      check({tag, " lf"},    32'(lf_en), 32'd1);
      check({tag, " gate"},  32'(gate), 32'b001);
      check({tag, " run"},   32'({slow_run, tmr_run}), 32'b11);
      check({tag, " aux"},   32'(aux_en), 32'd0);
      check({tag, " err"},   32'(err), 32'd0);
      check({tag, " wake"},  32'(waking), 32'd0);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_reset_state("R1 reset");

      // table walk: R2 R3 R4 R5 R6 R7 R8
      for (int i = 0; i < N_VEC; i++) begin
         vec_t v;
         v = vec_t'(VEC[i]);
         cfg_write(v.md, v.off, v.dv, v.pll, v.aux, '0);
         repeat (6) @(negedge clk);
         check($sformatf("R2/R3/R4 vec%0d mode", i), 32'(mode), 32'(v.e_md));
         check($sformatf("R2/R5/R7 vec%0d hf", i), 32'(hf_en), 32'(v.e_hf));
         check($sformatf("R2/R3/R4 vec%0d gate", i), 32'(gate), 32'(v.e_gate));
         check($sformatf("R7 vec%0d slow/tmr run", i), 32'({slow_run, tmr_run}), 32'({v.e_run, v.e_run}));
         check($sformatf("R7 vec%0d lf", i), 32'(lf_en), 32'd1);
         check($sformatf("R8 vec%0d aux", i), 32'(aux_en), 32'(v.e_aux));
         check($sformatf("R6 vec%0d err", i), 32'(err), 32'(v.e_err));
      end

      // R9: wake in Active has no effect
      pulse_wake();
      check("R9 wake in active waking", 32'(waking), 32'd0);
      check("R9 wake in active mode", 32'(mode), 32'd0);

      // R11: Main -> Slow break gap
      cfg_write(2'd1, 1'b0, 1'b0, 1'b0, '0, '0);
      check("R11 old gate held on write edge", 32'(gate), 32'b001);
      begin
         int zeros;
         zeros = 0;
         for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (gate == 3'b000) zeros++;
            else if (gate != 3'b100) check("R11 stray gate", 32'(gate), 32'b100);
         end
         check("R11 gap length", 32'(zeros), 32'(GAP_CYCLES));
         check("R11 new gate", 32'(gate), 32'b100);
      end

      // R9: wake from Halt with settle 3
      cfg_write(2'd3, 1'b0, 1'b0, 1'b1, 2'b11, 8'd3);
      repeat (4) @(negedge clk);
      check("R7 halt run", 32'({slow_run, tmr_run, hf_en}), 32'd0);
      pulse_wake();
      check("R9 waking after wake", 32'(waking), 32'd1);
      check("R9 hf on after wake", 32'(hf_en), 32'd1);
      check("R9 mode held halt", 32'(mode), 32'd3);
      repeat (3) @(negedge clk);
      check("R9 still halt at settle", 32'(mode), 32'd3);
      @(negedge clk);
      check("R9 active after settle", 32'(mode), 32'd0);
      check("R9 waking cleared", 32'(waking), 32'd0);
      @(negedge clk);
      check("R9 main gate restored", 32'(gate), 32'b001);
      check("R9 aux back", 32'(aux_en), 32'b11);

      // R10: wake and write in the same cycle, then a write during settle
      cfg_write(2'd2, 1'b0, 1'b0, 1'b0, '0, 8'd2);
      repeat (4) @(negedge clk);
      cfg_mode = 2'd1;
      cfg_we   = 1'b1;
      wake     = 1'b1;
      @(negedge clk);
      cfg_we   = 1'b0;
      wake     = 1'b0;
      check("R10 wake wins mode", 32'(mode), 32'd2);
      check("R10 wake wins waking", 32'(waking), 32'd1);
      cfg_write(2'd3, 1'b0, 1'b0, 1'b0, '0, '0);
      check("R10 write in settle ignored", 32'(mode), 32'd2);
      repeat (4) @(negedge clk);
      check("R10 ends active", 32'(mode), 32'd0);
      check("R10 gate main", 32'(gate), 32'b001);

      // R6: flag still sticky, cleared only by reset
      check("R6 err sticky", 32'(err), 32'd1);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_reset_state("R1 second reset");

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule